// File: doc/BRIEF.md
# Paged Serial EEPROM Model on a Two-Wire Bus

This block is a synthesizable model of a 128 KiB serial EEPROM that answers as a slave on a two-wire (I2C) bus. It oversamples the SCL and SDA lines with the system clock. It recognises its own 7-bit device address and takes a two-byte word address. It writes received bytes into a small synchronous RAM and shifts stored bytes back out on request. The word address is 17 bits wide. The top bit comes from the device-address byte, and the other sixteen come from the two address bytes that follow it.

Writes move through the array one 256-byte page at a time. The low address bits wrap inside the page, so a long page write never spills into the next page. Reads keep one counter across the whole 17-bit space and roll over to zero after the last location. The backing store is a parameterised RAM whose depth may be smaller than the logical array. In that case the word-address bits above the store width select nothing, and such locations alias onto one another.

A host drives the bus as a normal two-wire master. The strap input selects one of two device addresses. The only output is a pull-low enable for the open-drain SDA pad.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The block acknowledges a device-address byte only when its upper five bits are 10100 and bit 2 equals `addr_strap`. It acknowledges by pulling SDA low through the ninth clock. A byte that does not match gets no acknowledge, and the block then ignores all traffic (no acknowledge, no write) until the next START.
- R2: A write begins with a device byte with bit 0 = 0, then an address high byte, then an address low byte. The word address is {device bit 1, high byte, low byte}. Each data byte that follows is stored at the current word address and acknowledged.
- R3: During a write, each stored byte advances only the low 8 address bits. They wrap from 0xFF to 0x00 inside the same 256-byte page, and the upper 9 bits stay unchanged.
- R4: A device byte with bit 0 = 1 that is not preceded by an address phase returns the byte at the internal counter, and the counter then advances by one. Bit 1 of a read device byte is ignored.
- R5: A random read is an address-only write followed by a repeated START and a read device byte. It returns the byte at the word address just written.
- R6: Each byte the master acknowledges is followed by the byte at the next address, and this continues across page boundaries. After the master's NACK the block releases SDA and drives nothing until the next START.
- R7: The read counter rolls over from 0x1FFFF to 0x00000.
- R8: A START seen in the middle of a byte abandons that byte, which is not stored, and restarts device-address matching. A STOP in the middle of a byte returns the block to idle. Bytes completed before either event stay stored.
- R9: Read data leaves MSB first, and SDA changes only while SCL is low.
- R10: After reset SDA is released and the read counter is 0. The RAM contents survive a reset.
- R11: The store holds 2^STORE_AW bytes (2048 by default) indexed by the low STORE_AW word-address bits. Addresses that differ only above bit 10 therefore reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Level of the bus clock line |
| sda_in | input | 1 | Level of the bus data line |
| addr_strap | input | 1 | Board strap that selects bit 2 of the device address |
| sda_drive_low | output | 1 | When 1, the SDA pad pulls the line low; when 0, it releases the line |

## Verification
The bound checker watches several rules on every cycle:
- SDA changes only while the synchronised SCL is low.
- The idle state never pulls SDA.
- A START always leads to a fresh device-address byte, and a STOP always leads to idle.
- Each stored byte keeps the page and steps the low address bits.
- Each byte loaded for reading steps the full counter with rollover.
- Every stored byte is acknowledged.

Only the bench scenarios can show the rest:
- That data written through one access pattern comes back through another.
- That the strap and family bits select the device.
- That sequential reads cross pages while page writes wrap.
- That the counter rolls over at the top.
- That aborted bytes are dropped while completed ones remain.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    // Word address: one bit from the device byte plus two address bytes.
    localparam int WORD_AW = 17;

    // Upper five bits of the device-address byte.
    localparam logic [4:0] DEV_FAMILY = 5'b10100;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RX      = 3'd1,
        ST_RX_DONE = 3'd2,
        ST_RX_ACK  = 3'd3,
        ST_TX      = 3'd4,
        ST_TX_ACK  = 3'd5,
        ST_TX_LOAD = 3'd6
    } slv_state_e;

    typedef enum logic [1:0] {
        RX_DEV  = 2'd0,
        RX_AHI  = 2'd1,
        RX_ALO  = 2'd2,
        RX_DATA = 2'd3
    } rx_kind_e;

    typedef struct packed {
        slv_state_e           state;
        rx_kind_e             kind;
        logic [3:0]           bitcnt;
        logic [7:0]           shreg;
        logic [6:0]           txsh;
        logic [WORD_AW-1:0]   ptr;
        logic [7:0]           hi;
        logic                 p0;
        logic                 rd_pend;
        logic                 drive;
    } slv_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;

    // Idle bus is high, so reset to ones to avoid false edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_in};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_in};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_i2c_pkg::*;
#(
    parameter int PAGE_AW     = 8,
    parameter int STORE_AW    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic addr_strap,
    output logic sda_drive_low
);

    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic [7:0] rdata;
    logic       wr_en;
    logic       tx_load;

    slv_regs_t  q;
    slv_regs_t  n;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Read port follows the counter; it settles long before the next SCL fall.
    eeprom_store #(.AW(STORE_AW), .DW(8)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (q.ptr[STORE_AW-1:0]),
        .wdata (q.shreg),
        .raddr (q.ptr[STORE_AW-1:0]),
        .rdata (rdata)
    );

    always_comb begin
        n       = q;
        wr_en   = 1'b0;
        tx_load = 1'b0;

        if (stop_det) begin
            n.state = ST_IDLE;
            n.drive = 1'b0;
        end else if (start_det) begin
            n.state   = ST_RX;
            n.kind    = RX_DEV;
            n.bitcnt  = 4'd0;
            n.rd_pend = 1'b0;
            n.drive   = 1'b0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                end

                ST_RX: begin
                    if (scl_rise) begin
                        n.shreg  = {q.shreg[6:0], sda_s};
                        n.bitcnt = q.bitcnt + 4'd1;
                        if (q.bitcnt == 4'd7) begin
                            n.state = ST_RX_DONE;
                        end
                    end
                end

                ST_RX_DONE: begin
                    if (scl_fall) begin
                        n.state  = ST_RX_ACK;
                        n.drive  = 1'b1;
                        n.bitcnt = 4'd0;
                        case (q.kind)
                            RX_DEV: begin
                                if (q.shreg[7:3] == DEV_FAMILY && q.shreg[2] == addr_strap) begin
                                    n.rd_pend = q.shreg[0];
                                    if (!q.shreg[0]) begin
                                        n.p0   = q.shreg[1];
                                        n.kind = RX_AHI;
                                    end
                                end else begin
                                    n.state = ST_IDLE;
                                    n.drive = 1'b0;
                                end
                            end
                            RX_AHI: begin
                                n.hi   = q.shreg;
                                n.kind = RX_ALO;
                            end
                            RX_ALO: begin
                                n.ptr  = {q.p0, q.hi, q.shreg};
                                n.kind = RX_DATA;
                            end
                            RX_DATA: begin
                                wr_en = 1'b1;
                                n.ptr = {q.ptr[WORD_AW-1:PAGE_AW], q.ptr[PAGE_AW-1:0] + 1'b1};
                            end
                            default: begin
                            end
                        endcase
                    end
                end

                ST_RX_ACK: begin
                    if (scl_fall) begin
                        n.bitcnt = 4'd0;
                        if (q.rd_pend) begin
                            n.state = ST_TX;
                            n.txsh  = rdata[6:0];
                            n.drive = ~rdata[7];
                            n.ptr   = q.ptr + 1'b1;
                            tx_load = 1'b1;
                        end else begin
                            n.state = ST_RX;
                            n.drive = 1'b0;
                        end
                    end
                end

                ST_TX: begin
                    if (scl_rise) begin
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            n.drive = 1'b0;
                            n.state = ST_TX_ACK;
                        end else begin
                            n.drive = ~q.txsh[6];
                            n.txsh  = {q.txsh[5:0], 1'b0};
                        end
                    end
                end

                ST_TX_ACK: begin
                    if (scl_rise) begin
                        n.state = sda_s ? ST_IDLE : ST_TX_LOAD;
                    end
                end

                ST_TX_LOAD: begin
                    if (scl_fall) begin
                        n.state  = ST_TX;
                        n.bitcnt = 4'd0;
                        n.txsh   = rdata[6:0];
                        n.drive  = ~rdata[7];
                        n.ptr    = q.ptr + 1'b1;
                        tx_load  = 1'b1;
                    end
                end

                default: begin
                    n.state = ST_IDLE;
                    n.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign sda_drive_low = q.drive;

endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk
    import eeprom_i2c_pkg::*;
#(
    parameter int PAGE_AW = 8
) (
    input logic      clk,
    input logic      rst_n,
    input logic      scl_s,
    input logic      start_det,
    input logic      stop_det,
    input logic      sda_drive_low,
    input logic      wr_en,
    input logic      tx_load,
    input slv_regs_t q
);

    // R9
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_s);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> !sda_drive_low);

    // R8
    start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.state == ST_RX && q.kind == RX_DEV && q.bitcnt == 4'd0 && !sda_drive_low));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.state == ST_IDLE));

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q.ptr[WORD_AW-1:PAGE_AW] == $past(q.ptr[WORD_AW-1:PAGE_AW])));

    // R3
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q.ptr[PAGE_AW-1:0] == $past(q.ptr[PAGE_AW-1:0]) + 1'b1));

    // R4
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (q.ptr == $past(q.ptr) + 1'b1));

    // R2
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_drive_low);

endmodule

bind eeprom_i2c_slave eeprom_i2c_chk #(.PAGE_AW(PAGE_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_s         (scl_s),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sda_drive_low (sda_drive_low),
    .wr_en         (wr_en),
    .tx_load       (tx_load),
    .q             (q)
);

// File: tb/eeprom_i2c_slave_test.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_test;

    localparam int Q  = 5;
    localparam int NV = 6;
    // {write address, read-back address, data}
    localparam logic [41:0] VEC [NV] = '{
        {17'h00010, 17'h00010, 8'hA5},
        {17'h10123, 17'h00123, 8'h3C},
        {17'h007FF, 17'h007FF, 8'h5A},
        {17'h00400, 17'h00400, 8'hFF},
        {17'h0ABCD, 17'h0ABCD, 8'h96},
        {17'h00000, 17'h10000, 8'h77}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b1;
    logic sda_drive_low;
    logic sda_bus;
    int   n_chk = 0;
    int   n_fail = 0;
    logic ack;
    logic b;
    logic [7:0] rb;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_low;

    eeprom_i2c_slave uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_bus),
        .addr_strap    (strap),
        .sda_drive_low (sda_drive_low)
    );

    task automatic tick(input int cnt);
        repeat (cnt) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev(input logic p0, input logic rw);
        return {5'b10100, strap, p0, rw};
    endfunction

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic v);
        sda_m = v; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic v);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        v = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic a);
        logic t;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(t);
        a = ~t;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic a);
        logic t;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(t);
            v[i] = t;
        end
        send_bit(~a);
    endtask

    task automatic addr_phase(input logic [16:0] a, input string tag);
        i2c_start();
        write_byte(dev(a[16], 1'b0), ack); check({tag, " dev ack"}, ack, 1);
        write_byte(a[15:8], ack);          check({tag, " hi ack"}, ack, 1);
        write_byte(a[7:0], ack);           check({tag, " lo ack"}, ack, 1);
    endtask

    task automatic byte_write(input logic [16:0] a, input logic [7:0] d, input string tag);
        addr_phase(a, tag);
        write_byte(d, ack); check({tag, " data ack"}, ack, 1);
        i2c_stop();
    endtask

    task automatic rand_read_begin(input logic [16:0] a, input string tag);
        addr_phase(a, tag);
        i2c_start();
        write_byte(dev(1'b0, 1'b1), ack); check({tag, " read dev ack"}, ack, 1);
    endtask

    task automatic read_expect(input logic [7:0] exp, input logic last, input string tag);
        read_byte(rb, ~last);
        check(tag, rb, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check("R10 sda released after reset", sda_drive_low, 0);

        // Vector table: byte writes, then random reads of each location.
        for (int i = 0; i < NV; i++) begin
            byte_write(VEC[i][41:25], VEC[i][7:0], "R2 byte write");
        end
        for (int i = 0; i < NV; i++) begin
            rand_read_begin(VEC[i][24:8], "R5 random read");
            read_expect(VEC[i][7:0], 1'b1, "R5 R9 R11 random read data");
            i2c_stop();
        end

        // R1: strap bit mismatch gets no ACK and writes nothing.
        i2c_start();
        write_byte({5'b10100, ~strap, 1'b0, 1'b0}, ack); check("R1 foreign dev no ack", ack, 0);
        write_byte(8'h00, ack); check("R1 ignored hi no ack", ack, 0);
        write_byte(8'h10, ack); check("R1 ignored lo no ack", ack, 0);
        write_byte(8'h00, ack); check("R1 ignored data no ack", ack, 0);
        i2c_stop();
        i2c_start();
        write_byte(8'hA0 ^ 8'h40, ack); check("R1 wrong family no ack", ack, 0);
        i2c_stop();
        rand_read_begin(17'h00010, "R1 readback");
        read_expect(8'hA5, 1'b1, "R1 location untouched");
        i2c_stop();

        // R3: page write wraps inside the page.
        byte_write(17'h00300, 8'hE1, "R3 guard write");
        addr_phase(17'h002FE, "R3 page write");
        write_byte(8'h11, ack); check("R3 d0 ack", ack, 1);
        write_byte(8'h22, ack); check("R3 d1 ack", ack, 1);
        write_byte(8'h33, ack); check("R3 d2 ack", ack, 1);
        write_byte(8'h44, ack); check("R3 d3 ack", ack, 1);
        write_byte(8'h55, ack); check("R3 d4 ack", ack, 1);
        i2c_stop();

        // R6: sequential read crosses the page boundary.
        rand_read_begin(17'h002FE, "R6 seq read");
        read_expect(8'h11, 1'b0, "R6 seq byte 0");
        read_expect(8'h22, 1'b0, "R6 seq byte 1");
        read_expect(8'hE1, 1'b1, "R3 R6 next page untouched");
        check("R6 released after nack", sda_drive_low, 0);
        recv_bit(b);
        check("R6 no drive after nack", b, 1);
        i2c_stop();

        // R4: current-address read, P0 in read byte ignored.
        rand_read_begin(17'h00200, "R4 setup");
        read_expect(8'h33, 1'b1, "R3 wrapped byte");
        i2c_stop();
        i2c_start();
        write_byte(dev(1'b1, 1'b1), ack); check("R4 cur read ack", ack, 1);
        read_expect(8'h44, 1'b1, "R4 current read p0 ignored");
        i2c_stop();
        i2c_start();
        write_byte(dev(1'b0, 1'b1), ack); check("R4 cur read ack 2", ack, 1);
        read_expect(8'h55, 1'b1, "R4 current read advance");
        i2c_stop();

        // R7: counter rolls over at the top of the array.
        byte_write(17'h1FFFF, 8'hC3, "R7 top write");
        rand_read_begin(17'h1FFFF, "R7 rollover");
        read_expect(8'hC3, 1'b0, "R7 last byte");
        read_expect(8'h77, 1'b1, "R7 rolled to zero");
        i2c_stop();

        // R8: START in the middle of a data byte.
        addr_phase(17'h00400, "R8 abort");
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        i2c_start();
        write_byte(dev(1'b0, 1'b1), ack); check("R8 rematch after start", ack, 1);
        read_expect(8'hFF, 1'b1, "R8 partial byte dropped");
        i2c_stop();

        // R8: STOP in the middle of a data byte.
        addr_phase(17'h00010, "R8 stop abort");
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        i2c_stop();
        check("R8 released after stop", sda_drive_low, 0);
        rand_read_begin(17'h00010, "R8 readback");
        read_expect(8'hA5, 1'b1, "R8 stop kept old byte");
        i2c_stop();

        // R8: completed bytes survive an abort.
        addr_phase(17'h00500, "R8 keep");
        write_byte(8'hAA, ack); check("R8 keep d0 ack", ack, 1);
        write_byte(8'hBB, ack); check("R8 keep d1 ack", ack, 1);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        i2c_start();
        i2c_stop();
        rand_read_begin(17'h00500, "R8 keep readback");
        read_expect(8'hAA, 1'b0, "R8 kept byte 0");
        read_expect(8'hBB, 1'b1, "R8 kept byte 1");
        i2c_stop();

        // R10: reset clears counter, keeps the store.
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(5);
        i2c_start();
        write_byte(dev(1'b0, 1'b1), ack); check("R10 read ack after reset", ack, 1);
        read_expect(8'h77, 1'b1, "R10 counter zero after reset");
        i2c_stop();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule